// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters, each driven by its own power-of-two prescaler. A channel runs in one of two modes. In free-running mode it wraps from the top of its range to zero. In interval mode it returns to zero after it reaches a programmable limit. Reaching that limit raises a pending flag. Software clears the flag by reading it, and the flag drives a per-channel interrupt line when the interrupt is enabled.

Software reaches every register through a plain single-cycle read/write bus. Registers are arranged in six groups, and within a group the three channels sit one word apart. A typical use keeps one channel free-running as a timebase and programs another in interval mode to raise periodic or one-shot interrupts. To rearm a channel, software writes a restart command and clears the stop bit in the same write.

Top module: `triple_tick_timer`

## Requirements
- R1: After reset every channel is stopped (control bit 0 = 1), its count is 0, its prescaler is off (clock control reads 0), its limit register reads 0xFFFF, its enable and pending bits read 0, and no interrupt line is high.
- R2: Group base offsets are 0x00 clock control, 0x0C counter control, 0x18 live count (read-only), 0x24 limit, 0x54 pending status (read-only) and 0x60 interrupt enable. Channel n sits at base + 4·n. Reads of unmapped offsets return 0.
- R3: Clock control bit 0 enables the prescaler and bits [4:1] hold an exponent E. With the prescaler on, the count advances once every 2^(E+1) clocks counted from a restart. With it off, the count advances every clock.
- R4: Counter control bit 0 = 1 freezes the count. Writing it back to 0 lets counting resume from the held value.
- R5: Writing 1 to counter control bit 4 zeroes the count and the prescaler phase. The bit reads back as 0. Counter control bit 5 and clock control bit 5 are plain storage bits that read back as written.
- R6: With counter control bit 1 = 0 the count rolls from 0xFFFF to 0 and raises no pending flag.
- R7: With counter control bit 1 = 1, a tick taken while the count equals the limit returns the count to 0 and sets pending bit 0.
- R8: A channel's interrupt output is high exactly while its pending bit and its enable bit 0 are both set.
- R9: A read of a pending-status register clears it, unless a new event arrives in the same cycle, in which case the bit stays set.
- R10: A write addressed to one channel leaves the registers and the count of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as the strobe |
| irq | output | 3 | Level interrupt, one bit per channel |

## Verification
Tick rate is measured with the prescaler off and at exponents 0, 2 and 10. Each count is sampled one clock before and one clock on a tick boundary, which separates an off-by-one in the divider from a wrong exponent decode. The interval tests use a small limit and align status reads with the clocks just before and exactly on a limit event, so a plain clear-on-read can be told apart from the rule that a new event wins. A free-running run past 0xFFFF, a frozen-then-resumed count and reads of idle neighbour channels separate wrap, hold and isolation faults from general counting errors.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
   typedef enum logic [2:0] {
      G_CLK  = 3'd0,
      G_CTL  = 3'd1,
      G_CNT  = 3'd2,
      G_IVL  = 3'd3,
      G_STS  = 3'd4,
      G_IEN  = 3'd5,
      G_NONE = 3'd6
   } grp_e;

   localparam int NGRP       = 6;
   localparam int CH_STRIDE  = 4;
   localparam logic [7:0] GRP_BASE [NGRP] = '{8'h00, 8'h0C, 8'h18, 8'h24, 8'h54, 8'h60};

   // counter control bit positions
   localparam int CTL_STOP  = 0;
   localparam int CTL_MODE  = 1;
   localparam int CTL_RSTRT = 4;
   localparam int CTL_SPARE = 5;
   // clock control bit positions
   localparam int CKC_PSEN  = 0;
   localparam int CKC_EXP_LO = 1;
   localparam int CKC_SRC   = 5;
endpackage

// File: rtl/ttt_prescaler.sv
module ttt_prescaler #(
   parameter int EXP_W        = 4,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             clr,
   input  logic             ps_en,
   input  logic [EXP_W-1:0] expo,
   output logic             tick
);
   localparam int PW = 2 ** EXP_W;

   generate
      if (HAS_PRESCALE) begin : g_div
         logic [PW-1:0] phase_q;
         logic [PW-1:0] mask;
         logic [EXP_W:0] shamt;

         always_comb begin
            shamt = {1'b0, expo} + 1'b1;
            mask  = ~({PW{1'b1}} << shamt);
         end

         always_ff @(posedge clk) begin
            if (!rst_n)   phase_q <= '0;
            else if (clr) phase_q <= '0;
            else if (run) phase_q <= phase_q + 1'b1;
         end

         assign tick = run && !clr && (!ps_en || ((phase_q & mask) == mask));
      end else begin : g_nodiv
         logic unused_ok;
         assign unused_ok = ps_en ^ (^expo);
         assign tick = run && !clr;
      end
   endgenerate
endmodule

// File: rtl/ttt_decode.sv
module ttt_decode
   import ttt_pkg::*;
#(
   parameter int AW  = 8,
   parameter int NCH = 3,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic           en,
   input  logic           we,
   input  logic [AW-1:0]  addr,
   output grp_e           grp,
   output logic [CHW-1:0] chi,
   output logic [NCH-1:0] wr_clk,
   output logic [NCH-1:0] wr_ctl,
   output logic [NCH-1:0] wr_ivl,
   output logic [NCH-1:0] wr_ien,
   output logic [NCH-1:0] rd_sts
);
   always_comb begin
      grp = G_NONE;
      chi = '0;
      for (int g = 0; g < NGRP; g++) begin
         for (int c = 0; c < NCH; c++) begin
            if (addr == AW'(int'(GRP_BASE[g]) + CH_STRIDE * c)) begin
               grp = grp_e'(g);
               chi = CHW'(c);
            end
         end
      end
   end

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_strb
         logic here;
         assign here      = en && (grp != G_NONE) && (chi == CHW'(c));
         assign wr_clk[c] = here && we  && (grp == G_CLK);
         assign wr_ctl[c] = here && we  && (grp == G_CTL);
         assign wr_ivl[c] = here && we  && (grp == G_IVL);
         assign wr_ien[c] = here && we  && (grp == G_IEN);
         assign rd_sts[c] = here && !we && (grp == G_STS);
      end
   endgenerate
endmodule

// File: rtl/ttt_channel.sv
module ttt_channel
   import ttt_pkg::*;
#(
   parameter int CW           = 16,
   parameter int EXP_W        = 4,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_clk,
   input  logic          wr_ctl,
   input  logic          wr_ivl,
   input  logic          wr_ien,
   input  logic          rd_sts,
   input  logic [CW-1:0] wdata,
   output logic [5:0]    ckc_q,
   output logic [5:0]    ctl_view,
   output logic [CW-1:0] count_q,
   output logic [CW-1:0] limit_q,
   output logic          ien_q,
   output logic          sts_q,
   output logic          stop_q,
   output logic          mode_q,
   output logic          irq
);
   localparam int CKC_EXP_HI = CKC_EXP_LO + EXP_W - 1;

   logic spare_q;
   logic restart;
   logic tick;
   logic at_limit;
   logic event_hit;

   assign restart = wr_ctl && wdata[CTL_RSTRT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ckc_q   <= '0;
         stop_q  <= 1'b1;
         mode_q  <= 1'b0;
         spare_q <= 1'b0;
         limit_q <= '1;
         ien_q   <= 1'b0;
      end else begin
         if (wr_clk) ckc_q <= wdata[5:0];
         if (wr_ctl) begin
            stop_q  <= wdata[CTL_STOP];
            mode_q  <= wdata[CTL_MODE];
            spare_q <= wdata[CTL_SPARE];
         end
         if (wr_ivl) limit_q <= wdata;
         if (wr_ien) ien_q <= wdata[0];
      end
   end

   ttt_prescaler #(.EXP_W(EXP_W), .HAS_PRESCALE(HAS_PRESCALE)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (!stop_q),
      .clr   (restart),
      .ps_en (ckc_q[CKC_PSEN]),
      .expo  (ckc_q[CKC_EXP_HI:CKC_EXP_LO]),
      .tick  (tick)
   );

   assign at_limit  = mode_q && (count_q == limit_q);
   assign event_hit = tick && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n)        count_q <= '0;
      else if (restart)  count_q <= '0;
      else if (tick)     count_q <= at_limit ? '0 : count_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         sts_q <= 1'b0;
      else if (event_hit) sts_q <= 1'b1;
      else if (rd_sts)    sts_q <= 1'b0;
   end

   assign ctl_view = {spare_q, 1'b0, 2'b00, mode_q, stop_q};
   assign irq      = sts_q && ien_q;
endmodule

// File: rtl/triple_tick_timer.sv
module triple_tick_timer
   import ttt_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DW           = 16,
   parameter int CW           = 16,
   parameter int NCH          = 3,
   parameter int EXP_W        = 4,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bus_en,
   input  logic           bus_we,
   input  logic [AW-1:0]  bus_addr,
   input  logic [DW-1:0]  bus_wdata,
   output logic [DW-1:0]  bus_rdata,
   output logic [NCH-1:0] irq
);
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (NCH < 1 || NCH > 3) begin : g_bad_nch
         $error("NCH must be 1..3 to fit the 12-byte group stride");
      end
      if (DW < CW) begin : g_bad_dw
         $error("DW must hold a full count");
      end
      if (CW < 6) begin : g_bad_cw
         $error("CW must be at least 6");
      end
      if (AW < 7) begin : g_bad_aw
         $error("AW must reach offset 0x68");
      end
   endgenerate

   grp_e                     grp;
   logic [CHW-1:0]           chi;
   logic [NCH-1:0]           wr_clk, wr_ctl, wr_ivl, wr_ien, rd_sts;
   logic [NCH-1:0][5:0]      ckc_v, ctl_v;
   logic [NCH-1:0][CW-1:0]   cnt_v, lim_v;
   logic [NCH-1:0]           ien_v, sts_v, stop_v, mode_v;

   ttt_decode #(.AW(AW), .NCH(NCH)) u_dec (
      .en     (bus_en),
      .we     (bus_we),
      .addr   (bus_addr),
      .grp    (grp),
      .chi    (chi),
      .wr_clk (wr_clk),
      .wr_ctl (wr_ctl),
      .wr_ivl (wr_ivl),
      .wr_ien (wr_ien),
      .rd_sts (rd_sts)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         ttt_channel #(.CW(CW), .EXP_W(EXP_W), .HAS_PRESCALE(HAS_PRESCALE)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_clk   (wr_clk[c]),
            .wr_ctl   (wr_ctl[c]),
            .wr_ivl   (wr_ivl[c]),
            .wr_ien   (wr_ien[c]),
            .rd_sts   (rd_sts[c]),
            .wdata    (bus_wdata[CW-1:0]),
            .ckc_q    (ckc_v[c]),
            .ctl_view (ctl_v[c]),
            .count_q  (cnt_v[c]),
            .limit_q  (lim_v[c]),
            .ien_q    (ien_v[c]),
            .sts_q    (sts_v[c]),
            .stop_q   (stop_v[c]),
            .mode_q   (mode_v[c]),
            .irq      (irq[c])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_en && !bus_we) begin
         unique case (grp)
            G_CLK:   bus_rdata = DW'(ckc_v[chi]);
            G_CTL:   bus_rdata = DW'(ctl_v[chi]);
            G_CNT:   bus_rdata = DW'(cnt_v[chi]);
            G_IVL:   bus_rdata = DW'(lim_v[chi]);
            G_STS:   bus_rdata = DW'(sts_v[chi]);
            G_IEN:   bus_rdata = DW'(ien_v[chi]);
            default: bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ttt_checker.sv
module ttt_checker #(
   parameter int AW  = 8,
   parameter int DW  = 16,
   parameter int CW  = 16,
   parameter int NCH = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_en,
   input logic                   bus_we,
   input logic [AW-1:0]          bus_addr,
   input logic [DW-1:0]          bus_wdata,
   input logic [NCH-1:0]         irq,
   input logic [NCH-1:0][CW-1:0] cnt_v,
   input logic [NCH-1:0]         sts_v,
   input logic [NCH-1:0]         ien_v,
   input logic [NCH-1:0]         stop_v,
   input logic [NCH-1:0]         mode_v
);
   generate
      for (genvar c = 0; c < NCH; c++) begin : g_chk
         logic ctl_wr, sts_rd;
         assign ctl_wr = bus_en && bus_we && (bus_addr == AW'(8'h0C + 4 * c));
         assign sts_rd = bus_en && !bus_we && (bus_addr == AW'(8'h54 + 4 * c));

         assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_v[c] && !ctl_wr) |=> $stable(cnt_v[c]));

         assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_wr && bus_wdata[4]) |=> (cnt_v[c] == '0));

         assert_free_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_v[c] && !ctl_wr && (cnt_v[c] == '1)) |=> ((cnt_v[c] == '0) || (cnt_v[c] == '1)));

         assert_event_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_v[c]) |-> (cnt_v[c] == '0));

         assert_irq_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[c]) |-> ien_v[c]);

         assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            sts_rd |=> (!sts_v[c] || (cnt_v[c] == '0)));
      end
   endgenerate
endmodule

bind triple_tick_timer ttt_checker #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH)) u_ttt_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_en    (bus_en),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .cnt_v     (cnt_v),
   .sts_v     (sts_v),
   .ien_v     (ien_v),
   .stop_v    (stop_v),
   .mode_v    (mode_v)
);

// File: tb/tb_triple_tick_timer.sv
module tb_triple_tick_timer;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_CLK = 8'h00, A_CTL = 8'h0C, A_CNT = 8'h18,
                          A_IVL = 8'h24, A_STS = 8'h54, A_IEN = 8'h60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  irq;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   triple_tick_timer dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_en    (bus_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      rd(A_CTL, v);      check("R1 ctl0 stopped", v, 16'h0001);
      rd(A_IVL + 8, v);  check("R1 limit2", v, 16'hFFFF);
      rd(A_CLK + 4, v);  check("R1 clkctl1", v, 16'h0000);
      rd(A_CNT, v);      check("R1 count0", v, 16'h0000);
      rd(A_STS, v);      check("R1 status0", v, 16'h0000);
      rd(A_IEN + 8, v);  check("R1 enable2", v, 16'h0000);
      check("R1 irq idle", {13'b0, irq}, 16'h0000);
   endtask

   task automatic t_map();
      logic [15:0] v;
      wr(A_IVL + 4, 16'h1234);
      wr(A_IVL + 8, 16'h0055);
      rd(A_IVL, v);      check("R2 limit0 untouched", v, 16'hFFFF);
      rd(A_IVL + 4, v);  check("R2 limit1 stride", v, 16'h1234);
      rd(A_IVL + 8, v);  check("R2 limit2 stride", v, 16'h0055);
      rd(8'h30, v);      check("R2 unmapped hole", v, 16'h0000);
      rd(A_IEN + 12, v); check("R2 past last channel", v, 16'h0000);
   endtask

   task automatic t_rate();
      logic [15:0] v;
      int ex [3] = '{0, 2, 10};
      wr(A_CTL, 16'h0010);
      wait_clk(37);
      rd(A_CNT, v); check("R3 prescaler off", v, 16'd37);
      foreach (ex[i]) begin
         int dv = 1 << (ex[i] + 1);
         wr(A_CLK, 16'((ex[i] << 1) | 1));
         wr(A_CTL, 16'h0010);
         wait_clk(dv * 3 - 1);
         rd(A_CNT, v); check($sformatf("R3 exp %0d before tick", ex[i]), v, 16'd2);
         rd(A_CNT, v); check($sformatf("R3 exp %0d on tick", ex[i]), v, 16'd3);
      end
      wr(A_CLK, 16'h0000);
   endtask

   task automatic t_hold();
      logic [15:0] a, b;
      wr(A_CTL, 16'h0010);
      wait_clk(10);
      wr(A_CTL, 16'h0001);
      rd(A_CNT, a); check("R4 value at stop", a, 16'd11);
      wait_clk(20);
      rd(A_CNT, b); check("R4 held while stopped", b, a);
      wr(A_CTL, 16'h0000);
      wait_clk(5);
      rd(A_CNT, b); check("R4 resumes from held", b, 16'd16);
   endtask

   task automatic t_wrap();
      logic [15:0] v;
      wr(A_CTL, 16'h0010);
      wait_clk(65535);
      rd(A_CNT, v); check("R6 reaches max", v, 16'hFFFF);
      rd(A_CNT, v); check("R6 rolls to zero", v, 16'h0000);
      rd(A_STS, v); check("R6 no event free mode", v, 16'h0000);
   endtask

   task automatic t_cmd();
      logic [15:0] v;
      wr(A_CTL, 16'h0030);
      rd(A_CTL, v);  check("R5 restart bit reads 0, spare kept", v, 16'h0020);
      wr(A_CLK, 16'h0020);
      rd(A_CLK, v);  check("R5 source bit storage", v, 16'h0020);
      wr(A_CLK, 16'h0000);
      wr(A_CTL, 16'h0011);
      rd(A_CNT, v);  check("R5 restart while stopped", v, 16'h0000);
   endtask

   task automatic t_interval();
      logic [15:0] v;
      wr(A_IVL, 16'd4);
      wr(A_IEN, 16'h0001);
      wr(A_CTL, 16'h0012);
      wait_clk(4);
      rd(A_CNT, v); check("R7 at limit", v, 16'd4);
      check("R8 irq raised", {15'b0, irq[0]}, 16'd1);
      rd(A_CNT, v); check("R7 back to zero", v, 16'd0);
      rd(A_STS, v); check("R7 pending set", v, 16'd1);
      check("R9 irq drops after read", {15'b0, irq[0]}, 16'd0);
      rd(A_STS, v); check("R9 pending cleared", v, 16'd0);
      wait_clk(1);
      rd(A_STS, v); check("R9 pre-collision value", v, 16'd0);
      check("R9 event beats read", {15'b0, irq[0]}, 16'd1);
      rd(A_STS, v); check("R9 still pending", v, 16'd1);
   endtask

   task automatic t_gate();
      logic [15:0] v;
      wr(A_IVL + 8, 16'd2);
      wr(A_CTL + 8, 16'h0012);
      wait_clk(10);
      check("R8 masked irq2", {15'b0, irq[2]}, 16'd0);
      rd(A_STS + 8, v); check("R8 status2 set though masked", v, 16'd1);
   endtask

   task automatic t_iso();
      logic [15:0] v;
      rd(A_CNT + 4, v); check("R10 ch1 count idle", v, 16'd0);
      rd(A_CTL + 4, v); check("R10 ch1 still stopped", v, 16'h0001);
      rd(A_IVL, v);     check("R10 limit0 kept", v, 16'd4);
      check("R10 irq1 quiet", {15'b0, irq[1]}, 16'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map();
      t_rate();
      t_hold();
      t_wrap();
      t_cmd();
      t_interval();
      t_gate();
      t_iso();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule